// File: doc/BRIEF.md
# Chip-wise SEC-DED ECC merge and check unit

This unit protects a 64-byte memory line as eight independent 8-byte words, one per x8 DRAM chip. Each word, which is the data a single chip delivers over its eight burst beats, carries its own 8-bit single-error-correct, double-error-detect check byte. A line therefore needs eight check bytes, the same 12.5% overhead as a conventional layout. Because every word has its own check byte, one chip can be read on its own (fine-grained) or all chips can be read together (coarse-grained), and both use the same stored check bytes.

On the write-back side the unit takes the line, a per-word valid and dirty mask, the check bytes kept in the cache for words never fetched, and the column address. It returns the merged check bytes: fresh ones for valid words and the cached ones, untouched, for invalid words. It also returns a per-word write mask, and the index of the sub-rank that holds the line's check block. That index rotates with the column address modulo 9, so check blocks spread evenly over the nine sub-ranks.

On the read side a single 8-byte word and its check byte are presented with a strobe. One cycle later the unit gives the corrected word, a corrected flag and an uncorrectable flag.

Top module: `chipwise_ecc_unit`

## Requirements
- R1: For a valid word i (line_data bits 64i+63..64i), merged_ecc bits 8i+7..8i hold its check byte. The code is defined as follows. Data bit j sits at the (j+1)-th integer of 3 and up that is not a power of two. Check bits 6..0 are the XOR of the positions of all set data bits. Check bit 7 makes the even parity of the 64 data bits and check bits 6..0 together.
- R2: For an invalid word i, merged_ecc bits 8i+7..8i equal cached_ecc bits 8i+7..8i unchanged, whatever the word's data.
- R3: wr_mask bit i is 1 exactly when word i is both valid and dirty.
- R4: ecc_subrank equals col_addr modulo 9, in the range 0 to 8, and is combinational.
- R5: chk_valid is high in the cycle after rd_valid and low otherwise. chk_data and the two flags change only on a cycle with rd_valid and hold their values between reads.
- R6: A read whose word and check byte form a valid codeword returns the word unchanged with both flags low.
- R7: A read with one flipped data bit returns the original word with chk_corrected high and chk_uncorrectable low.
- R8: A read with one flipped check bit, including bit 7, returns the word unchanged with chk_corrected high.
- R9: A read with two flipped bits anywhere in the 72 returns the word as received with chk_uncorrectable high and chk_corrected low.
- R10: During reset chk_valid, chk_data, chk_corrected and chk_uncorrectable are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_data | input | 512 | Line being written back, word i in bits 64i+63..64i |
| word_valid | input | 8 | Word holds fetched data |
| word_dirty | input | 8 | Word was modified |
| cached_ecc | input | 64 | Check bytes kept for unfetched words |
| col_addr | input | 12 | Column address bits above the line offset |
| rd_valid | input | 1 | Single-word read strobe |
| rd_data | input | 64 | Word read from one chip |
| rd_ecc | input | 8 | Check byte for that word |
| merged_ecc | output | 64 | Check bytes to write back |
| wr_mask | output | 8 | Per-word write enable |
| ecc_subrank | output | 4 | Sub-rank holding the check block |
| chk_valid | output | 1 | Read result valid |
| chk_data | output | 64 | Corrected word |
| chk_corrected | output | 1 | A single-bit error was corrected |
| chk_uncorrectable | output | 1 | A double-bit error was detected |

## Verification
The merge and sub-rank paths hold no state, so a fault in them shows up at the same moment at merged_ecc, wr_mask or ecc_subrank for the offending word or address. The mod-9 sweep covers every column value, and the merge checks mix valid and invalid words. The read path has a single register stage. A wrong syndrome decode shows in the cycle after the strobe as a wrong data bit or a wrong flag. A held-value fault shows on the first idle cycle that follows a read. The read vectors flip data bits at both ends of the word, each kind of check bit, and mixed data/check pairs, so every branch of the decode is reached.

// File: rtl/chipwise_ecc_unit.sv
module chipwise_ecc_unit #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 64,
  parameter int CHK_W  = 8,
  parameter int COL_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WORDS*WORD_W-1:0]   line_data,
  input  logic [WORDS-1:0]          word_valid,
  input  logic [WORDS-1:0]          word_dirty,
  input  logic [WORDS*CHK_W-1:0]    cached_ecc,
  input  logic [COL_W-1:0]          col_addr,
  input  logic                      rd_valid,
  input  logic [WORD_W-1:0]         rd_data,
  input  logic [CHK_W-1:0]          rd_ecc,
  output logic [WORDS*CHK_W-1:0]    merged_ecc,
  output logic [WORDS-1:0]          wr_mask,
  output logic [3:0]                ecc_subrank,
  output logic                      chk_valid,
  output logic [WORD_W-1:0]         chk_data,
  output logic                      chk_corrected,
  output logic                      chk_uncorrectable
);

  localparam int HAM_W  = CHK_W - 1;
  localparam int DIGITS = (COL_W + 2) / 3;
  localparam int NEG_D  = DIGITS / 2;
  localparam int BIAS   = 9 * ((7 * NEG_D + 8) / 9);

  function automatic logic [HAM_W-1:0] ham_bits(input logic [WORD_W-1:0] d);
    logic [HAM_W-1:0] acc;
    logic [31:0]      pos;
    acc = '0;
    pos = 32'd2;
    for (int i = 0; i < WORD_W; i++) begin
      pos = pos + 32'd1;
      if ((pos & (pos - 32'd1)) == 32'd0) pos = pos + 32'd1;
      for (int k = 0; k < HAM_W; k++)
        if (pos[k]) acc[k] = acc[k] ^ d[i];
    end
    return acc;
  endfunction

  function automatic logic [CHK_W-1:0] encode(input logic [WORD_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = ham_bits(d);
    return {(^d) ^ (^h), h};
  endfunction

  function automatic logic [WORD_W-1:0] flip_mask(input logic [HAM_W-1:0] s);
    logic [WORD_W-1:0] m;
    logic [31:0]       pos;
    m   = '0;
    pos = 32'd2;
    for (int i = 0; i < WORD_W; i++) begin
      pos = pos + 32'd1;
      if ((pos & (pos - 32'd1)) == 32'd0) pos = pos + 32'd1;
      m[i] = (pos[HAM_W-1:0] == s);
    end
    return m;
  endfunction

  // write-back merge
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] wd;
    assign wd = line_data[w*WORD_W +: WORD_W];
    assign merged_ecc[w*CHK_W +: CHK_W] =
      word_valid[w] ? encode(wd) : cached_ecc[w*CHK_W +: CHK_W];
  end

  assign wr_mask = word_valid & word_dirty;

  // sub-rank rotation: alternating sum of 3-bit digits, since 8 = -1 mod 9
  logic [DIGITS*3-1:0] colx;
  assign colx = (DIGITS*3)'(col_addr);

  always_comb begin
    int acc;
    acc = BIAS;
    for (int g = 0; g < DIGITS; g++) begin
      if (g % 2 == 0) acc = acc + int'(colx[3*g +: 3]);
      else            acc = acc - int'(colx[3*g +: 3]);
    end
    for (int r = 0; r < DIGITS + 2; r++)
      if (acc >= 9) acc = acc - 9;
    ecc_subrank = 4'(acc);
  end

  // single-word check
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic [WORD_W-1:0] fmask;
  logic              hit, syn_pow2, fix_ok, bad;
  logic [WORD_W-1:0] fixed;

  assign syn      = rd_ecc[HAM_W-1:0] ^ ham_bits(rd_data);
  assign odd      = (^rd_data) ^ (^rd_ecc);
  assign fmask    = flip_mask(syn);
  assign hit      = |fmask;
  assign syn_pow2 = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
  assign fix_ok   = odd && (syn == '0 || syn_pow2 || hit);
  assign bad      = (syn != '0) && !fix_ok;
  assign fixed    = (odd && hit) ? (rd_data ^ fmask) : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid         <= 1'b0;
      chk_data          <= '0;
      chk_corrected     <= 1'b0;
      chk_uncorrectable <= 1'b0;
    end else begin
      chk_valid <= rd_valid;
      if (rd_valid) begin
        chk_data          <= fixed;
        chk_corrected     <= fix_ok;
        chk_uncorrectable <= bad;
      end
    end
  end

  a_r4_subrank_step: assert property (@(posedge clk) disable iff (!rst_n)
    (col_addr == $past(col_addr) + 1'b1 && $past(col_addr) != '1) |->
    (ecc_subrank == (($past(ecc_subrank) == 4'd8) ? 4'd0 : $past(ecc_subrank) + 4'd1)));

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (chk_valid == $past(rd_valid)));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_corrected && chk_uncorrectable));

  a_r9_raw_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (chk_uncorrectable -> chk_data == $past(rd_data)));

  a_r7_one_bit_fix: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> ($countones(chk_data ^ $past(rd_data)) <= 1));

endmodule

// File: tb/tb_chipwise_ecc_unit.sv
module tb_chipwise_ecc_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [511:0] line_data = '0;
  logic [7:0]   word_valid = '0;
  logic [7:0]   word_dirty = '0;
  logic [63:0]  cached_ecc = '0;
  logic [11:0]  col_addr = '0;
  logic         rd_valid = 1'b0;
  logic [63:0]  rd_data = '0;
  logic [7:0]   rd_ecc = '0;
  logic [63:0]  merged_ecc;
  logic [7:0]   wr_mask;
  logic [3:0]   ecc_subrank;
  logic         chk_valid;
  logic [63:0]  chk_data;
  logic         chk_corrected;
  logic         chk_uncorrectable;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int pos_of [64];

  always #10 clk = ~clk;

  chipwise_ecc_unit dut (
    .clk(clk), .rst_n(rst_n), .line_data(line_data), .word_valid(word_valid),
    .word_dirty(word_dirty), .cached_ecc(cached_ecc), .col_addr(col_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ecc(rd_ecc),
    .merged_ecc(merged_ecc), .wr_mask(wr_mask), .ecc_subrank(ecc_subrank),
    .chk_valid(chk_valid), .chk_data(chk_data), .chk_corrected(chk_corrected),
    .chk_uncorrectable(chk_uncorrectable)
  );

  // read vectors: data, 72-bit flip (63..0 data, 71..64 check), class 0 clean 1 fixed 2 double
  localparam logic [63:0] T_DATA [8] = '{
    64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0000_0001, 64'h8000_0000_0000_0000,
    64'h5A5A_5A5A_A5A5_A5A5, 64'h0000_0000_0000_0000, 64'hFEDC_BA98_7654_3210,
    64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFFF_FFFF };
  localparam logic [71:0] T_FLIP [8] = '{
    72'h0, 72'h1, 72'h00_8000_0000_0000_0000, 72'h08_0000_0000_0000_0000,
    72'h80_0000_0000_0000_0000, 72'h00_0000_0100_0000_0020,
    72'h04_0000_0000_0000_0400, 72'h0 };
  localparam int T_CLASS [8] = '{0, 1, 1, 1, 1, 2, 2, 0};

  function automatic logic [7:0] ref_code(input logic [63:0] d);
    logic [6:0] x;
    x = '0;
    for (int j = 0; j < 64; j++)
      if (d[j]) x = x ^ 7'(pos_of[j]);
    return {^{d, x}, x};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    begin
      int p = 3;
      for (int j = 0; j < 64; j++) begin
        if ((p & (p - 1)) == 0) p++;
        pos_of[j] = p;
        p++;
      end
    end

    // R10 reset state
    repeat (2) @(negedge clk);
    check(chk_valid == 0 && chk_corrected == 0 && chk_uncorrectable == 0, "R10",
          "flags in reset", {61'd0, chk_valid, chk_corrected, chk_uncorrectable}, 64'd0);
    check(chk_data == 64'd0, "R10", "data in reset", chk_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // read vector table: R6 R7 R8 R9 R5
    for (int t = 0; t < 8; t++) begin
      logic [71:0] cw;
      logic [63:0] exp_d;
      cw = {ref_code(T_DATA[t]), T_DATA[t]} ^ T_FLIP[t];
      rd_data  = cw[63:0];
      rd_ecc   = cw[71:64];
      rd_valid = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0;
      exp_d = (T_CLASS[t] == 2) ? cw[63:0] : T_DATA[t];
      check(chk_valid == 1'b1, "R5", "valid after strobe", 64'(chk_valid), 64'd1);
      check(chk_data == exp_d, (T_CLASS[t] == 2) ? "R9" : "R6/R7/R8",
            "read data", chk_data, exp_d);
      check(chk_corrected == (T_CLASS[t] == 1) &&
            chk_uncorrectable == (T_CLASS[t] == 2),
            (T_CLASS[t] == 0) ? "R6" : (T_CLASS[t] == 1) ? "R7/R8" : "R9",
            "flags {corr,uncorr}", {62'd0, chk_corrected, chk_uncorrectable},
            {62'd0, T_CLASS[t] == 1, T_CLASS[t] == 2});
    end

    // R5 hold between reads
    rd_data = 64'hAAAA_AAAA_AAAA_AAAA;
    rd_ecc  = 8'h00;
    @(negedge clk);
    check(chk_valid == 1'b0, "R5", "valid idle", 64'(chk_valid), 64'd0);
    check(chk_data == 64'hFFFF_FFFF_FFFF_FFFF, "R5", "data held",
          chk_data, 64'hFFFF_FFFF_FFFF_FFFF);

    // write-back merge R1 R2 R3
    for (int c = 0; c < 4; c++) begin
      logic [7:0] vmask [4];
      logic [7:0] dmask [4];
      vmask = '{8'hFF, 8'h00, 8'hA6, 8'h51};
      dmask = '{8'h0F, 8'hFF, 8'h24, 8'hF3};
      for (int w = 0; w < 8; w++) begin
        line_data[64*w +: 64] = {32'hC0DE_0000 + 32'(w * 7 + c), 32'h1357_9BDF ^ 32'(w << (c + 3))};
        cached_ecc[8*w +: 8]  = 8'(8'h3C + w * 17 + c);
      end
      word_valid = vmask[c];
      word_dirty = dmask[c];
      #2;
      check(wr_mask == (vmask[c] & dmask[c]), "R3", "write mask",
            64'(wr_mask), 64'(vmask[c] & dmask[c]));
      for (int w = 0; w < 8; w++) begin
        logic [7:0] e;
        e = vmask[c][w] ? ref_code(line_data[64*w +: 64]) : cached_ecc[8*w +: 8];
        check(merged_ecc[8*w +: 8] == e, vmask[c][w] ? "R1" : "R2", "merged byte",
              64'(merged_ecc[8*w +: 8]), 64'(e));
      end
    end

    // R4 sub-rank for every column value
    for (int a = 0; a < 4096; a++) begin
      col_addr = a[11:0];
      #1;
      check(ecc_subrank == 4'(a % 9), "R4", "subrank", 64'(ecc_subrank), 64'(a % 9));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule